// File: doc/BRIEF.md
# Hardware Loop Sequencer

This block sits beside a 32-bit instruction fetch unit and keeps the state of one zero-overhead hardware loop: the address of the first instruction of the loop body, the address of its last instruction and an iteration count. A loop is opened by one of two start commands. The counted form also carries a count. The endless form does not, and it is told apart by bit 0 of the stored end address, which is set to 1. The low bit of every instruction address is always zero, so that bit is free to hold the mode.

Every retiring instruction presents its PC. When that PC equals the loop end address (bit 0 ignored) and a loop is active, the block raises a redirect request in the same cycle, pointing at the loop begin address. A counted loop spends one unit of its count on each redirect. When the count is already zero at the end of the body, the loop falls through and closes. An endless loop keeps redirecting until software rewrites its begin or end register.

A register port lets control-register move instructions read and write the three loop registers. This allows a loop context to be saved, restored or cancelled.

Top module: `hwloop_ctrl`

## Requirements
- R1: A counted start (`cnt_start_i`) loads begin with `start_pc_i + 4`, end with `start_pc_i` plus the sign-extended 17-bit `start_disp_i` whose bit 0 is treated as 0 (so end bit 0 is 0), and count with `start_count_i`, and makes the loop active.
- R2: An endless start (`inf_start_i`) loads begin with `start_pc_i + 4` and end with the same sum as R1 but with bit 0 forced to 1. The count register keeps its value, and the loop becomes active.
- R3: `redirect_o` is 1 exactly in a cycle where `retire_i` is 1, a loop is active, `retire_pc_i` equals the end register with bit 0 cleared, and R4/R5 allow it. `redirect_pc_o` then equals the begin register. Both are combinational from the inputs of that cycle.
- R4: In counted mode (end bit 0 = 0), a matching retire with a nonzero count redirects and decrements the count by one. A matching retire with count zero does not redirect and makes the loop inactive, so later matches do not redirect.
- R5: In endless mode (end bit 0 = 1), every matching retire redirects and the count register is left unchanged.
- R6: A register write to begin or to end makes the loop inactive. A write to end also sets the mode from bit 0 of the written value. A write to count loads it and leaves the active state and mode unchanged.
- R7: `reg_sel_i` selects the register: 0 = begin, 1 = end, 2 = count, 3 = none. `reg_rdata_o` shows the selected register combinationally (0 for select 3). A write with select 3 changes nothing.
- R8: A synchronous active-high reset clears begin, end and count to 0 and makes the loop inactive, so no redirect follows.
- R9: The next-state priority is counted start, then endless start, then register write, then the retire update. A redirect in a cycle is decided from the state held before that cycle's update.
- R10: A retire whose PC does not match the end address causes no redirect and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_start_i | input | 1 | Counted-loop start command |
| inf_start_i | input | 1 | Endless-loop start command |
| start_pc_i | input | 32 | PC of the loop start instruction |
| start_disp_i | input | 17 | Signed displacement to the last body instruction |
| start_count_i | input | 32 | Iteration count for a counted start |
| retire_i | input | 1 | Retire strobe |
| retire_pc_i | input | 32 | PC of the retiring instruction |
| reg_wr_i | input | 1 | Loop register write strobe |
| reg_sel_i | input | 2 | Loop register select (0 begin, 1 end, 2 count, 3 none) |
| reg_wdata_i | input | 32 | Loop register write data |
| reg_rdata_o | output | 32 | Selected loop register value |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 32 | Redirect target address |

## Verification
Directed sequences run counted loops with counts of 2, 0 and 1. These show whether the decrement happens per loop-back and whether a zero count closes the loop instead of redirecting. Odd and negative displacements tell a correct sign extension and bit-0 mask apart from a plain add. Endless loops are retired many times and then cancelled through each writable register, which separates the mode bit from the active flag. Same-cycle starts and writes check the priority order. A long randomised mix then steers retire PCs onto and off the end address while a behavioural model is compared on every clock.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [1:0] {
        LSEL_BEGIN = 2'd0,
        LSEL_END   = 2'd1,
        LSEL_COUNT = 2'd2,
        LSEL_NONE  = 2'd3
    } lsel_e;

endpackage

// File: rtl/hwloop_target.sv
module hwloop_target #(
    parameter int AW         = 32,
    parameter int DW         = 17,
    parameter int INSN_BYTES = 4
) (
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] disp_i,
    output logic [AW-1:0] begin_o,
    output logic [AW-1:0] end_even_o
);
    localparam logic [AW-1:0] STEP  = AW'(INSN_BYTES);
    localparam logic [AW-1:0] EVEN  = ~AW'(1);

    logic [AW-1:0] disp_sx;

    always_comb begin
        disp_sx    = {{(AW-DW){disp_i[DW-1]}}, disp_i} & EVEN;
        begin_o    = pc_i + STEP;
        end_even_o = pc_i + disp_sx;
    end
endmodule

// File: rtl/hwloop_hit.sv
module hwloop_hit #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          retire_i,
    input  logic [AW-1:0] retire_pc_i,
    input  logic [AW-1:0] end_q_i,
    input  logic [CW-1:0] count_q_i,
    input  logic          active_q_i,
    output logic          take_o,
    output logic          spend_o,
    output logic          close_o
);
    localparam logic [AW-1:0] EVEN = ~AW'(1);

    logic match;
    logic endless;
    logic cnt_zero;

    always_comb begin
        endless  = end_q_i[0];
        cnt_zero = (count_q_i == '0);
        match    = retire_i && active_q_i && (retire_pc_i == (end_q_i & EVEN));
        take_o   = match && (endless || !cnt_zero);
        spend_o  = match && !endless && !cnt_zero;
        close_o  = match && !endless && cnt_zero;
    end
endmodule

// File: rtl/hwloop_rdmux.sv
module hwloop_rdmux #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic [1:0]    sel_i,
    input  logic [AW-1:0] begin_i,
    input  logic [AW-1:0] end_i,
    input  logic [CW-1:0] count_i,
    output logic [AW-1:0] rdata_o
);
    import hwloop_pkg::*;

    logic [AW-1:0] count_w;

    generate
        if (CW == AW) begin : g_same
            assign count_w = count_i;
        end else begin : g_pad
            assign count_w = {{(AW-CW){1'b0}}, count_i};
        end
    endgenerate

    always_comb begin
        case (lsel_e'(sel_i))
            LSEL_BEGIN: rdata_o = begin_i;
            LSEL_END:   rdata_o = end_i;
            LSEL_COUNT: rdata_o = count_w;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int AW         = 32,
    parameter int DW         = 17,
    parameter int CW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_start_i,
    input  logic          inf_start_i,
    input  logic [AW-1:0] start_pc_i,
    input  logic [DW-1:0] start_disp_i,
    input  logic [CW-1:0] start_count_i,
    input  logic          retire_i,
    input  logic [AW-1:0] retire_pc_i,
    input  logic          reg_wr_i,
    input  logic [1:0]    reg_sel_i,
    input  logic [AW-1:0] reg_wdata_i,
    output logic [AW-1:0] reg_rdata_o,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o
);
    import hwloop_pkg::*;

    typedef struct packed {
        logic [AW-1:0] lbeg;
        logic [AW-1:0] lend;
        logic [CW-1:0] lcnt;
        logic          act;
    } loop_st_t;

    loop_st_t st_d, st_q;

    logic [AW-1:0] tgt_begin;
    logic [AW-1:0] tgt_end_even;
    logic          hit_take;
    logic          hit_spend;
    logic          hit_close;

    // Plain views of the state for the bound checker
    logic [AW-1:0] beg_q;
    logic [AW-1:0] end_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;

    assign beg_q = st_q.lbeg;
    assign end_q = st_q.lend;
    assign cnt_q = st_q.lcnt;
    assign act_q = st_q.act;

    hwloop_target #(.AW(AW), .DW(DW), .INSN_BYTES(INSN_BYTES)) u_target (
        .pc_i       (start_pc_i),
        .disp_i     (start_disp_i),
        .begin_o    (tgt_begin),
        .end_even_o (tgt_end_even)
    );

    hwloop_hit #(.AW(AW), .CW(CW)) u_hit (
        .retire_i    (retire_i),
        .retire_pc_i (retire_pc_i),
        .end_q_i     (st_q.lend),
        .count_q_i   (st_q.lcnt),
        .active_q_i  (st_q.act),
        .take_o      (hit_take),
        .spend_o     (hit_spend),
        .close_o     (hit_close)
    );

    hwloop_rdmux #(.AW(AW), .CW(CW)) u_rdmux (
        .sel_i   (reg_sel_i),
        .begin_i (st_q.lbeg),
        .end_i   (st_q.lend),
        .count_i (st_q.lcnt),
        .rdata_o (reg_rdata_o)
    );

    assign redirect_o    = hit_take;
    assign redirect_pc_o = st_q.lbeg;

    always_comb begin
        st_d = st_q;
        if (cnt_start_i) begin
            st_d.lbeg = tgt_begin;
            st_d.lend = tgt_end_even;
            st_d.lcnt = start_count_i;
            st_d.act  = 1'b1;
        end else if (inf_start_i) begin
            st_d.lbeg = tgt_begin;
            st_d.lend = tgt_end_even | AW'(1);
            st_d.act  = 1'b1;
        end else if (reg_wr_i) begin
            case (lsel_e'(reg_sel_i))
                LSEL_BEGIN: begin
                    st_d.lbeg = reg_wdata_i;
                    st_d.act  = 1'b0;
                end
                LSEL_END: begin
                    st_d.lend = reg_wdata_i;
                    st_d.act  = 1'b0;
                end
                LSEL_COUNT: st_d.lcnt = reg_wdata_i[CW-1:0];
                default: ;
            endcase
        end else if (hit_spend) begin
            st_d.lcnt = st_q.lcnt - CW'(1);
        end else if (hit_close) begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

module hwloop_ctrl_chk #(
    parameter int AW         = 32,
    parameter int CW         = 32,
    parameter int INSN_BYTES = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_start_i,
    input logic          inf_start_i,
    input logic          reg_wr_i,
    input logic [1:0]    reg_sel_i,
    input logic [AW-1:0] start_pc_i,
    input logic          retire_i,
    input logic          redirect_o,
    input logic [AW-1:0] beg_q,
    input logic [AW-1:0] end_q,
    input logic [CW-1:0] cnt_q,
    input logic          act_q
);
    AST_CNT_START_BEGIN: assert property (@(posedge clk) disable iff (rst)
        cnt_start_i |=> (beg_q == $past(start_pc_i) + AW'(INSN_BYTES)) && act_q); // R1

    AST_CNT_START_MODE: assert property (@(posedge clk) disable iff (rst)
        cnt_start_i |=> !end_q[0]); // R1

    AST_INF_START_MODE: assert property (@(posedge clk) disable iff (rst)
        (inf_start_i && !cnt_start_i) |=> end_q[0] && act_q && (cnt_q == $past(cnt_q))); // R2

    AST_REDIRECT_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> retire_i && act_q); // R3

    AST_COUNT_SPENT: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !end_q[0] && !cnt_start_i && !inf_start_i && !reg_wr_i)
            |=> cnt_q == $past(cnt_q) - CW'(1)); // R4

    AST_ENDLESS_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && end_q[0] && !cnt_start_i && !inf_start_i && !reg_wr_i)
            |=> $stable(cnt_q) && act_q); // R5

    AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && !cnt_start_i && !inf_start_i && (reg_sel_i < 2'd2)) |=> !act_q); // R6
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW), .INSN_BYTES(INSN_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_start_i (cnt_start_i),
    .inf_start_i (inf_start_i),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .start_pc_i  (start_pc_i),
    .retire_i    (retire_i),
    .redirect_o  (redirect_o),
    .beg_q       (beg_q),
    .end_q       (end_q),
    .cnt_q       (cnt_q),
    .act_q       (act_q)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_start_i, inf_start_i;
    logic [31:0] start_pc_i;
    logic [16:0] start_disp_i;
    logic [31:0] start_count_i;
    logic        retire_i;
    logic [31:0] retire_pc_i;
    logic        reg_wr_i;
    logic [1:0]  reg_sel_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_beg, m_fin, m_cnt;
    bit          m_act;

    always #4 clk = ~clk;

    hwloop_ctrl uut (
        .clk(clk), .rst(rst),
        .cnt_start_i(cnt_start_i), .inf_start_i(inf_start_i),
        .start_pc_i(start_pc_i), .start_disp_i(start_disp_i),
        .start_count_i(start_count_i),
        .retire_i(retire_i), .retire_pc_i(retire_pc_i),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] disp_even(logic [16:0] d);
        logic signed [31:0] s;
        s = 32'($signed(d));
        return s & 32'hFFFF_FFFE;
    endfunction

    function automatic bit exp_redirect();
        return retire_i && m_act && (retire_pc_i == {m_fin[31:1], 1'b0})
               && (m_fin[0] || m_cnt != 0);
    endfunction

    function automatic logic [31:0] exp_rdata();
        case (reg_sel_i)
            2'd0: return m_beg;
            2'd1: return m_fin;
            2'd2: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle();
        cnt_start_i = 0; inf_start_i = 0; start_pc_i = 0; start_disp_i = 0;
        start_count_i = 0; retire_i = 0; retire_pc_i = 0; reg_wr_i = 0;
        reg_sel_i = 2'd3; reg_wdata_i = 0;
    endtask

    // Compare against the model, then advance one clock; called just after a negedge
    task automatic tick(string tag);
        bit er;
        #2;
        er = exp_redirect();
        chk(tag, {31'h0, redirect_o}, {31'h0, er});
        if (er) chk(tag, redirect_pc_o, m_beg);
        chk(tag, reg_rdata_o, exp_rdata());
        @(posedge clk);
        if (rst) begin
            m_beg = 0; m_fin = 0; m_cnt = 0; m_act = 0;
        end else if (cnt_start_i) begin
            m_beg = start_pc_i + 4;
            m_fin = start_pc_i + disp_even(start_disp_i);
            m_cnt = start_count_i; m_act = 1;
        end else if (inf_start_i) begin
            m_beg = start_pc_i + 4;
            m_fin = (start_pc_i + disp_even(start_disp_i)) | 32'h1;
            m_act = 1;
        end else if (reg_wr_i) begin
            case (reg_sel_i)
                2'd0: begin m_beg = reg_wdata_i; m_act = 0; end
                2'd1: begin m_fin = reg_wdata_i; m_act = 0; end
                2'd2: m_cnt = reg_wdata_i;
                default: ;
            endcase
        end else if (retire_i && m_act && retire_pc_i == {m_fin[31:1], 1'b0}) begin
            if (!m_fin[0]) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else m_act = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic peek(logic [1:0] sel, logic [31:0] exp, string tag);
        idle(); reg_sel_i = sel;
        #1 chk(tag, reg_rdata_o, exp);
        tick(tag);
    endtask

    task automatic retire_at(logic [31:0] pc, bit exp_r, logic [31:0] exp_pc, string tag);
        idle(); retire_i = 1; retire_pc_i = pc;
        #1 chk(tag, {31'h0, redirect_o}, {31'h0, exp_r});
        if (exp_r) chk(tag, redirect_pc_o, exp_pc);
        tick(tag);
    endtask

    task automatic cstart(logic [31:0] pc, logic [16:0] d, logic [31:0] c, string tag);
        idle(); cnt_start_i = 1; start_pc_i = pc; start_disp_i = d; start_count_i = c;
        tick(tag);
    endtask

    task automatic istart(logic [31:0] pc, logic [16:0] d, string tag);
        idle(); inf_start_i = 1; start_pc_i = pc; start_disp_i = d;
        tick(tag);
    endtask

    task automatic wreg(logic [1:0] sel, logic [31:0] v, string tag);
        idle(); reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = v;
        tick(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_beg = 0; m_fin = 0; m_cnt = 0; m_act = 0;
        idle(); rst = 1;
        @(negedge clk); tick("R8"); tick("R8");
        rst = 0;

        // R8: reset state
        peek(2'd0, 32'h0, "R8"); peek(2'd1, 32'h0, "R8"); peek(2'd2, 32'h0, "R8");
        retire_at(32'h0, 1'b0, 32'h0, "R8");

        // R1: counted start with odd displacement, count 2
        cstart(32'h0000_1000, 17'h00041, 32'd2, "R1");
        peek(2'd0, 32'h0000_1004, "R1"); peek(2'd1, 32'h0000_1040, "R1");
        peek(2'd2, 32'd2, "R1"); peek(2'd3, 32'h0, "R7");
        // R10: non-matching retire
        retire_at(32'h0000_1044, 1'b0, 32'h0, "R10");
        retire_at(32'h0000_1041, 1'b0, 32'h0, "R10");
        peek(2'd2, 32'd2, "R10");
        // R3/R4: two loop-backs then fall through
        retire_at(32'h0000_1040, 1'b1, 32'h0000_1004, "R3");
        peek(2'd2, 32'd1, "R4");
        retire_at(32'h0000_1040, 1'b1, 32'h0000_1004, "R4");
        peek(2'd2, 32'd0, "R4");
        retire_at(32'h0000_1040, 1'b0, 32'h0, "R4");
        retire_at(32'h0000_1040, 1'b0, 32'h0, "R4");

        // R1: negative displacement, count 0 closes at first match
        cstart(32'h0000_2000, 17'h1FFF1, 32'd0, "R1");
        peek(2'd1, 32'h0000_1FF0, "R1");
        retire_at(32'h0000_1FF0, 1'b0, 32'h0, "R4");
        retire_at(32'h0000_1FF0, 1'b0, 32'h0, "R4");

        // R2/R5: endless loop keeps count and redirects repeatedly
        cstart(32'h0000_0100, 17'h00010, 32'd7, "R1");
        istart(32'h0000_3000, 17'h00020, "R2");
        peek(2'd0, 32'h0000_3004, "R2"); peek(2'd1, 32'h0000_3021, "R2");
        peek(2'd2, 32'd7, "R2");
        for (int i = 0; i < 5; i++) retire_at(32'h0000_3020, 1'b1, 32'h0000_3004, "R5");
        peek(2'd2, 32'd7, "R5");

        // R6: count write keeps endless loop running, begin write cancels
        wreg(2'd2, 32'd9, "R6");
        retire_at(32'h0000_3020, 1'b1, 32'h0000_3004, "R6");
        wreg(2'd0, 32'h0000_3008, "R6");
        retire_at(32'h0000_3020, 1'b0, 32'h0, "R6");
        // R6: end write cancels and sets mode bit
        istart(32'h0000_4000, 17'h00040, "R2");
        wreg(2'd1, 32'h0000_4040, "R6");
        peek(2'd1, 32'h0000_4040, "R6");
        retire_at(32'h0000_4040, 1'b0, 32'h0, "R6");

        // R7: select 3 write ignored
        cstart(32'h0000_5000, 17'h00010, 32'd3, "R1");
        wreg(2'd3, 32'hDEAD_BEEF, "R7");
        peek(2'd0, 32'h0000_5004, "R7"); peek(2'd1, 32'h0000_5010, "R7");
        peek(2'd2, 32'd3, "R7");
        retire_at(32'h0000_5010, 1'b1, 32'h0000_5004, "R7");

        // R9: both starts at once -> counted wins; start beats write
        idle(); cnt_start_i = 1; inf_start_i = 1; start_pc_i = 32'h6000;
        start_disp_i = 17'h00030; start_count_i = 32'd1;
        reg_wr_i = 1; reg_sel_i = 2'd0; reg_wdata_i = 32'h1234;
        tick("R9");
        peek(2'd1, 32'h0000_6030, "R9"); peek(2'd0, 32'h0000_6004, "R9");
        // R9: start in same cycle as matching retire: redirect from old loop
        idle(); retire_i = 1; retire_pc_i = 32'h6030; inf_start_i = 1;
        start_pc_i = 32'h7000; start_disp_i = 17'h00008;
        #1 chk("R9", {31'h0, redirect_o}, 32'h1);
        chk("R9", redirect_pc_o, 32'h0000_6004);
        tick("R9");
        peek(2'd2, 32'd1, "R9");
        retire_at(32'h0000_7008, 1'b1, 32'h0000_7004, "R9");

        // R3: randomised mix against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            reg_sel_i = 2'($urandom_range(0, 3));
            if (r < 4) begin
                cnt_start_i = 1; start_pc_i = {$urandom_range(0, 255), 2'b00};
                start_disp_i = 17'($urandom); start_count_i = $urandom_range(0, 3);
            end else if (r < 7) begin
                inf_start_i = 1; start_pc_i = {$urandom_range(0, 255), 2'b00};
                start_disp_i = 17'($urandom);
            end else if (r < 10) begin
                reg_wr_i = 1; reg_wdata_i = $urandom_range(0, 1023);
            end
            if ($urandom_range(0, 3) != 0) begin
                retire_i = 1;
                retire_pc_i = ($urandom_range(0, 3) != 0) ? {m_fin[31:1], 1'b0}
                                                         : 32'($urandom_range(0, 1023));
            end
            tick("R3");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule